// File: doc/BRIEF.md
# Control Transfer Status-Stage Responder

This block is the device-side sequencer that closes a control transfer whose status phase runs from host to device. A lower packet layer hands it decoded events: a token strobe with PID, device address, endpoint and an error flag, and a data strobe with PID, payload length and a CRC verdict. Firmware contributes a one-cycle strobe when it writes the end-of-packet register, and stage control supplies a level saying the status phase is currently allowed, a level requesting a stall, and a pulse marking the start of a new SETUP.

An accepted OUT token arms the sequencer, and the data packet that follows decides the outcome. The block answers with ACK once firmware has committed and the packet is a clean zero-length DATA1. It answers with NAK while firmware has not yet committed. It answers with STALL whenever a stall is requested. It answers with silence when the packet is corrupt. Each outcome leaves a code in a status field, and an interrupt pulse accompanies the two outcomes that end the stage (ACK and STALL). A SETUP arriving mid-stage abandons the stage and records an abort code.

Top module: `ctl_status_hs`

## Requirements
- R1: During reset and on the first cycle after it, `hs_vld`=0, `hs_code`=00, `stat_code`=00, `stat_irq`=0 and `eop_flag`=0. Reset is synchronous and active low.
- R2: An OUT token (PID 4'b0001) is accepted only if all three hold: `tok_addr` equals `cfg_addr`, `tok_ep` equals the control endpoint (0), and `tok_err` is low. After a rejected token, a following data packet gets no handshake and leaves `stat_code` and `eop_flag` unchanged.
- R3: An OUT token that arrives while `stage_en` is low is rejected. The following data packet gets no handshake and changes no state.
- R4: An armed stage answers the data packet with NAK (`hs_code`=10) when `eop_flag` is low. `stat_code` is unchanged and no interrupt is raised.
- R5: When `eop_flag` is high and the data packet is DATA1 (PID 4'b1011) with length 0 and CRC good, the block sends ACK (`hs_code`=01). It also sets `stat_code` to READY (01), raises `stat_irq` and clears `eop_flag`.
- R6: When `eop_flag` is high and the data packet has a bad CRC, a PID other than DATA1, or a nonzero length, the block sends no handshake. It sets `stat_code` to RX_ERR (10), raises no interrupt and keeps `eop_flag` set.
- R7: With `stall_req` high at the data packet, the block sends STALL (`hs_code`=11) whatever the packet contents. It sets `stat_code` to READY, raises `stat_irq` and clears `eop_flag`.
- R8: A `setup_seen` pulse while `stage_en` is high and the stage has not completed since the last accepted token sets `stat_code` to ABORT (11), clears `eop_flag` and disarms the stage. After a completed stage, `setup_seen` leaves `stat_code` unchanged.
- R9: A pulse on `eop_wr` sets `eop_flag`. The flag then stays set until a completion (ACK or STALL) or a SETUP clears it.
- R10: Handshake, status and interrupt outputs change on the clock edge after the data cycle. `hs_vld` and `stat_irq` each last one cycle, and `hs_code` is 00 whenever `hs_vld` is low.
- R11: A data packet that arrives without a preceding accepted token gets no handshake and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_addr | input | ADDR_W | Assigned device address |
| stage_en | input | 1 | Status phase currently permitted |
| stall_req | input | 1 | Stall condition requested |
| setup_seen | input | 1 | Pulse: a new SETUP has begun |
| eop_wr | input | 1 | Pulse: firmware wrote end-of-packet register |
| tok_vld | input | 1 | Token event strobe |
| tok_pid | input | 4 | Token PID |
| tok_addr | input | ADDR_W | Token address field |
| tok_ep | input | EP_W | Token endpoint field |
| tok_err | input | 1 | Token CRC or format error |
| dat_vld | input | 1 | Data packet event strobe |
| dat_pid | input | 4 | Data PID |
| dat_len | input | LEN_W | Data payload length in bytes |
| dat_crc_ok | input | 1 | Data CRC verdict |
| hs_vld | output | 1 | Handshake request strobe |
| hs_code | output | 2 | 00 none, 01 ACK, 10 NAK, 11 STALL |
| stat_code | output | 2 | 00 clear, 01 READY, 10 RX_ERR, 11 ABORT |
| stat_irq | output | 1 | Status interrupt pulse |
| eop_flag | output | 1 | Sticky end-of-packet commit flag |

## Verification
The assertions check several properties on every cycle. The handshake code stays quiet when no strobe is present, and handshakes never come back to back. The interrupt is raised only together with ACK or STALL, and ACK always carries READY status. NAK is raised only while the commit flag is low, and no handshake follows a SETUP. The commit flag obeys its set and hold rules. Only the bench scenarios can show that each concrete sequence leads to the right outcome: rejected tokens, a disabled stage, the three kinds of data fault, a stall overriding bad data, an abort versus a SETUP after completion, and an orphan data packet.

// File: rtl/ctl_status_pkg.sv
package ctl_status_pkg;

    typedef enum logic [1:0] {
        HS_NONE  = 2'b00,
        HS_ACK   = 2'b01,
        HS_NAK   = 2'b10,
        HS_STALL = 2'b11
    } hs_e;

    typedef enum logic [1:0] {
        ST_CLEAR = 2'b00,
        ST_READY = 2'b01,
        ST_RXERR = 2'b10,
        ST_ABORT = 2'b11
    } stat_e;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_WAIT = 1'b1
    } phase_e;

    localparam logic [3:0] PID_OUT   = 4'b0001;
    localparam logic [3:0] PID_DATA1 = 4'b1011;

    typedef struct packed {
        phase_e phase;
        logic   hs_vld;
        hs_e    hs;
        stat_e  stat;
        logic   irq;
        logic   cmpl;
    } fsm_s;

endpackage

// File: rtl/ctl_tok_match.sv
module ctl_tok_match
    import ctl_status_pkg::*;
#(
    parameter int ADDR_W  = 7,
    parameter int EP_W    = 4,
    parameter int CTRL_EP = 0
) (
    input  logic              tok_vld,
    input  logic [3:0]        tok_pid,
    input  logic [ADDR_W-1:0] tok_addr,
    input  logic [EP_W-1:0]   tok_ep,
    input  logic              tok_err,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic              stage_en,
    output logic              tok_hit
);
    localparam logic [EP_W-1:0] EP_SEL = EP_W'(CTRL_EP);

    logic id_ok;

    always_comb begin
        id_ok   = (tok_addr == cfg_addr) && (tok_ep == EP_SEL) && !tok_err;
        tok_hit = tok_vld && (tok_pid == PID_OUT) && id_ok && stage_en;
    end
endmodule

// File: rtl/ctl_data_judge.sv
module ctl_data_judge
    import ctl_status_pkg::*;
#(
    parameter int LEN_W = 10
) (
    input  logic [3:0]       dat_pid,
    input  logic [LEN_W-1:0] dat_len,
    input  logic             dat_crc_ok,
    output logic             dat_good
);
    always_comb begin
        dat_good = dat_crc_ok && (dat_pid == PID_DATA1) && (dat_len == '0);
    end
endmodule

// File: rtl/ctl_eop_latch.sv
module ctl_eop_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    logic flag_d, flag_q;

    always_comb begin
        flag_d = flag_q;
        if (clr_i) flag_d = 1'b0;
        if (set_i) flag_d = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= flag_d;
    end

    assign flag_o = flag_q;

    assert_eop_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(set_i) && $past(rst_n)) |-> flag_o);

    assert_eop_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(flag_o) && !$past(clr_i) && $past(rst_n)) |-> flag_o);
endmodule

// File: rtl/ctl_status_hs.sv
module ctl_status_hs
    import ctl_status_pkg::*;
#(
    parameter int ADDR_W  = 7,
    parameter int EP_W    = 4,
    parameter int LEN_W   = 10,
    parameter int CTRL_EP = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic              stage_en,
    input  logic              stall_req,
    input  logic              setup_seen,
    input  logic              eop_wr,
    input  logic              tok_vld,
    input  logic [3:0]        tok_pid,
    input  logic [ADDR_W-1:0] tok_addr,
    input  logic [EP_W-1:0]   tok_ep,
    input  logic              tok_err,
    input  logic              dat_vld,
    input  logic [3:0]        dat_pid,
    input  logic [LEN_W-1:0]  dat_len,
    input  logic              dat_crc_ok,
    output logic              hs_vld,
    output logic [1:0]        hs_code,
    output logic [1:0]        stat_code,
    output logic              stat_irq,
    output logic              eop_flag
);
    localparam fsm_s FSM_RST = '{phase: PH_IDLE, hs_vld: 1'b0, hs: HS_NONE,
                                 stat: ST_CLEAR, irq: 1'b0, cmpl: 1'b0};

    logic tok_hit, dat_good, eop_clr;
    fsm_s st_d, st_q;

    ctl_tok_match #(.ADDR_W(ADDR_W), .EP_W(EP_W), .CTRL_EP(CTRL_EP)) u_tok (
        .tok_vld (tok_vld),
        .tok_pid (tok_pid),
        .tok_addr(tok_addr),
        .tok_ep  (tok_ep),
        .tok_err (tok_err),
        .cfg_addr(cfg_addr),
        .stage_en(stage_en),
        .tok_hit (tok_hit)
    );

    ctl_data_judge #(.LEN_W(LEN_W)) u_dat (
        .dat_pid   (dat_pid),
        .dat_len   (dat_len),
        .dat_crc_ok(dat_crc_ok),
        .dat_good  (dat_good)
    );

    ctl_eop_latch u_eop (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (eop_wr),
        .clr_i (eop_clr),
        .flag_o(eop_flag)
    );

    always_comb begin
        st_d        = st_q;
        st_d.hs_vld = 1'b0;
        st_d.hs     = HS_NONE;
        st_d.irq    = 1'b0;
        eop_clr     = 1'b0;
        if (setup_seen) begin
            if (stage_en && !st_q.cmpl) st_d.stat = ST_ABORT;
            st_d.phase = PH_IDLE;
            eop_clr    = 1'b1;
        end else if (tok_vld) begin
            st_d.phase = tok_hit ? PH_WAIT : PH_IDLE;
            if (tok_hit) st_d.cmpl = 1'b0;
        end else if (dat_vld && st_q.phase == PH_WAIT) begin
            st_d.phase = PH_IDLE;
            if (stall_req) begin
                st_d.hs_vld = 1'b1;
                st_d.hs     = HS_STALL;
                st_d.stat   = ST_READY;
                st_d.irq    = 1'b1;
                st_d.cmpl   = 1'b1;
                eop_clr     = 1'b1;
            end else if (!eop_flag) begin
                st_d.hs_vld = 1'b1;
                st_d.hs     = HS_NAK;
            end else if (dat_good) begin
                st_d.hs_vld = 1'b1;
                st_d.hs     = HS_ACK;
                st_d.stat   = ST_READY;
                st_d.irq    = 1'b1;
                st_d.cmpl   = 1'b1;
                eop_clr     = 1'b1;
            end else begin
                st_d.stat = ST_RXERR;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= FSM_RST;
        else        st_q <= st_d;
    end

    assign hs_vld    = st_q.hs_vld;
    assign hs_code   = st_q.hs;
    assign stat_code = st_q.stat;
    assign stat_irq  = st_q.irq;

    assert_hs_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_vld != (hs_code != 2'b00)) == 1'b0);

    assert_hs_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        hs_vld |=> !hs_vld);

    assert_irq_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        stat_irq |-> (hs_vld && (hs_code == 2'b01 || hs_code == 2'b11)));

    assert_ack_ready_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_vld && hs_code == 2'b01) |-> (stat_code == 2'b01));

    assert_nak_noeop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_vld && hs_code == 2'b10) |-> !$past(eop_flag));

    assert_setup_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(setup_seen) && $past(rst_n)) |-> !hs_vld);
endmodule

// File: tb/ctl_status_hs_bench.sv
module ctl_status_hs_bench;
    localparam int ADDR_W = 7;
    localparam int EP_W   = 4;
    localparam int LEN_W  = 10;
    localparam logic [ADDR_W-1:0] MY_ADDR = 7'h15;

    typedef struct {
        string      tag;
        logic [6:0] val;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic stage_en = 1'b0, stall_req = 1'b0, setup_seen = 1'b0, eop_wr = 1'b0;
    logic tok_vld = 1'b0, tok_err = 1'b0, dat_vld = 1'b0, dat_crc_ok = 1'b0;
    logic [3:0] tok_pid = '0, dat_pid = '0;
    logic [ADDR_W-1:0] tok_addr = '0;
    logic [EP_W-1:0] tok_ep = '0;
    logic [LEN_W-1:0] dat_len = '0;
    logic hs_vld, stat_irq, eop_flag;
    logic [1:0] hs_code, stat_code;

    int n_vec = 0, n_bad = 0;
    bit done = 1'b0;
    exp_t sb[$];
    logic [1:0] m_stat = 2'b00;
    logic m_eop = 1'b0;

    always #10 clk = ~clk;

    ctl_status_hs u_ctl_status_hs (
        .clk(clk), .rst_n(rst_n), .cfg_addr(MY_ADDR), .stage_en(stage_en),
        .stall_req(stall_req), .setup_seen(setup_seen), .eop_wr(eop_wr),
        .tok_vld(tok_vld), .tok_pid(tok_pid), .tok_addr(tok_addr), .tok_ep(tok_ep),
        .tok_err(tok_err), .dat_vld(dat_vld), .dat_pid(dat_pid), .dat_len(dat_len),
        .dat_crc_ok(dat_crc_ok), .hs_vld(hs_vld), .hs_code(hs_code),
        .stat_code(stat_code), .stat_irq(stat_irq), .eop_flag(eop_flag)
    );

    // expected vector: {hs_vld, hs_code, stat_code, irq, eop}
    task automatic push(input string tag, input logic hv, input logic [1:0] hc,
                        input logic irq);
        exp_t e;
        e.tag = tag;
        e.val = {hv, hc, m_stat, irq, m_eop};
        sb.push_back(e);
    endtask

    always @(negedge clk) begin
        if (sb.size() > 0) begin
            exp_t e;
            logic [6:0] act;
            e = sb.pop_front();
            act = {hs_vld, hs_code, stat_code, stat_irq, eop_flag};
            n_vec++;
            if (act !== e.val) begin
                n_bad++;
                $display("FAIL %s: got %b expected %b", e.tag, act, e.val);
            end
        end
    end

    task automatic idle_check(input string tag);
        @(negedge clk);
        @(posedge clk);
        push(tag, 1'b0, 2'b00, 1'b0);
    endtask

    task automatic send_tok(input logic [ADDR_W-1:0] a, input logic [EP_W-1:0] ep,
                            input logic err);
        @(negedge clk);
        tok_vld = 1'b1; tok_pid = 4'b0001; tok_addr = a; tok_ep = ep; tok_err = err;
        @(negedge clk);
        tok_vld = 1'b0;
    endtask

    task automatic send_dat(input string tag, input logic [3:0] pid,
                            input logic [LEN_W-1:0] len, input logic crc,
                            input logic hv, input logic [1:0] hc, input logic irq,
                            input logic [1:0] nstat, input logic neop);
        @(negedge clk);
        dat_vld = 1'b1; dat_pid = pid; dat_len = len; dat_crc_ok = crc;
        @(posedge clk);
        m_stat = nstat; m_eop = neop;
        push(tag, hv, hc, irq);
        @(negedge clk);
        dat_vld = 1'b0;
    endtask

    task automatic pulse_eop(input string tag);
        @(negedge clk);
        eop_wr = 1'b1;
        @(posedge clk);
        m_eop = 1'b1;
        push(tag, 1'b0, 2'b00, 1'b0);
        @(negedge clk);
        eop_wr = 1'b0;
    endtask

    task automatic pulse_setup(input string tag, input logic [1:0] nstat);
        @(negedge clk);
        setup_seen = 1'b1;
        @(posedge clk);
        m_stat = nstat; m_eop = 1'b0;
        push(tag, 1'b0, 2'b00, 1'b0);
        @(negedge clk);
        setup_seen = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        push("R1 in reset", 1'b0, 2'b00, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        idle_check("R1 after reset");
        stage_en = 1'b1;

        // R4: not yet committed -> NAK
        send_tok(MY_ADDR, 0, 1'b0);
        send_dat("R4 nak", 4'b1011, 0, 1'b1, 1'b1, 2'b10, 1'b0, 2'b00, 1'b0);
        // R9: sticky commit flag
        pulse_eop("R9 set");
        idle_check("R9 hold");
        idle_check("R9 hold2");
        // R6: three kinds of fault
        send_tok(MY_ADDR, 0, 1'b0);
        send_dat("R6 crc", 4'b1011, 0, 1'b0, 1'b0, 2'b00, 1'b0, 2'b10, 1'b1);
        send_tok(MY_ADDR, 0, 1'b0);
        send_dat("R6 pid", 4'b0011, 0, 1'b1, 1'b0, 2'b00, 1'b0, 2'b10, 1'b1);
        send_tok(MY_ADDR, 0, 1'b0);
        send_dat("R6 len", 4'b1011, 1, 1'b1, 1'b0, 2'b00, 1'b0, 2'b10, 1'b1);
        // R5: success, then R10 one-cycle pulse
        send_tok(MY_ADDR, 0, 1'b0);
        send_dat("R5 ack", 4'b1011, 0, 1'b1, 1'b1, 2'b01, 1'b1, 2'b01, 1'b0);
        push("R10 pulse ends", 1'b0, 2'b00, 1'b0);
        // R2: rejected tokens
        pulse_eop("R9 set again");
        send_tok(MY_ADDR ^ 7'h01, 0, 1'b0);
        send_dat("R2 addr", 4'b1011, 0, 1'b1, 1'b0, 2'b00, 1'b0, 2'b01, 1'b1);
        send_tok(MY_ADDR, 4'd2, 1'b0);
        send_dat("R2 ep", 4'b1011, 0, 1'b1, 1'b0, 2'b00, 1'b0, 2'b01, 1'b1);
        send_tok(MY_ADDR, 0, 1'b1);
        send_dat("R2 err", 4'b1011, 0, 1'b1, 1'b0, 2'b00, 1'b0, 2'b01, 1'b1);
        // R3: stage disabled
        stage_en = 1'b0;
        send_tok(MY_ADDR, 0, 1'b0);
        send_dat("R3 disabled", 4'b1011, 0, 1'b1, 1'b0, 2'b00, 1'b0, 2'b01, 1'b1);
        stage_en = 1'b1;
        // R11: orphan data
        send_dat("R11 orphan", 4'b1011, 0, 1'b1, 1'b0, 2'b00, 1'b0, 2'b01, 1'b1);
        // R7: move to RX_ERR, then stall over bad data
        send_tok(MY_ADDR, 0, 1'b0);
        send_dat("R6 pre-stall", 4'b1011, 0, 1'b0, 1'b0, 2'b00, 1'b0, 2'b10, 1'b1);
        stall_req = 1'b1;
        send_tok(MY_ADDR, 0, 1'b0);
        send_dat("R7 stall", 4'b0011, 3, 1'b0, 1'b1, 2'b11, 1'b1, 2'b01, 1'b0);
        stall_req = 1'b0;
        // R8: abort mid-stage, data afterwards ignored
        pulse_eop("R9 set 3");
        send_tok(MY_ADDR, 0, 1'b0);
        pulse_setup("R8 abort", 2'b11);
        send_dat("R8 disarmed", 4'b1011, 0, 1'b1, 1'b0, 2'b00, 1'b0, 2'b11, 1'b0);
        // R8: SETUP after completion keeps READY
        pulse_eop("R9 set 4");
        send_tok(MY_ADDR, 0, 1'b0);
        send_dat("R5 ack 2", 4'b1011, 0, 1'b1, 1'b1, 2'b01, 1'b1, 2'b01, 1'b0);
        pulse_setup("R8 after done", 2'b01);
        idle_check("R8 settle");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 5000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule